// File: doc/BRIEF.md
# Latched Event Status and Interrupt Pin Controller

This block gathers single-cycle event pulses from six directional tap detectors (positive and negative on each of three axes) and from the sample-acquisition path. It holds them as sticky flags in an 8-bit status word that a bus read clears. A bus slave presents the status word to a host. The host's read strobe wipes every flag and re-arms them for new events. While a bus transaction is open the flags are frozen, so a multi-byte read sees consistent data. Events that arrive during that window are held and land once the bus goes idle.

A per-source enable mask chooses which latched flags drive the interrupt pin. The flags themselves latch whatever the mask says. A first-only mode keeps the tap flag that latched first and drops later tap events until the next read. The pin can be active-high or active-low, and it can be driven push-pull or open-drain. The output is a data bit plus an output enable, so the pad ring can model a released pin.

Top module: `irqstat_top`

## Requirements
- R1: After reset the status word reads 0x00. The interrupt pin is at its inactive level, with output enable high in push-pull mode and low in open-drain mode.
- R2: A pulse on tap_evt[i] sets status bit i at the next clock edge. The bit mapping is 0 = X positive, 1 = X negative, 2 = Y positive, 3 = Y negative, 4 = Z positive, 5 = Z negative.
- R3: A pulse on smp_evt sets status bit 7 at the next clock edge, whatever the enables and the latch mode. Status bit 6 always reads 0.
- R4: A cycle with stat_rd high clears every status bit at the next edge. An event applied in that same cycle is latched, not lost.
- R5: Flags latch whether or not their enable is set. The interrupt is active exactly when some status bit is set and its enable is set. irq_en[5:0] map to status bits 5:0, and irq_en[6] maps to status bit 7.
- R6: With first_only high, once any tap flag is set, further tap events are dropped (not held) until a read. If several tap events apply together while no tap flag is set, only the lowest-numbered one latches. With first_only low, tap flags accumulate.
- R7: While bus_busy is high, no status bit becomes set. Events seen during that time are held and set at the edge where bus_busy is first sampled low. A read during bus_busy still clears the flags.
- R8: With irq_push_pull high, irq_oe is always 1. With it low, irq_oe is 1 only while the interrupt is active. irq_o is 1 when active and irq_pol_high is high, or when inactive and irq_pol_high is low; otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tap_evt | input | 6 | Tap event pulses, one per axis direction |
| smp_evt | input | 1 | Sample-acquired pulse |
| bus_busy | input | 1 | High while a bus transaction is open (START to STOP) |
| stat_rd | input | 1 | Status read strobe, clears flags |
| irq_en | input | 7 | Interrupt enables: [5:0] taps, [6] sample |
| first_only | input | 1 | Keep only the first latched tap flag |
| irq_pol_high | input | 1 | 1 = active-high pin, 0 = active-low |
| irq_push_pull | input | 1 | 1 = push-pull, 0 = open-drain |
| stat_q | output | 8 | Status word |
| irq_o | output | 1 | Pin data level |
| irq_oe | output | 1 | Pin output enable |

## Verification
The embedded assertions watch, on every cycle, several properties:
- flags stay frozen under bus_busy;
- a read with nothing arriving leaves an all-zero word;
- a tap flag latched in first-only mode is never joined by another;
- a sample event always reaches bit 7;
- a busy cycle with an event leaves something pending;
- the push-pull and open-drain enable rules hold.

The lowest-index choice among simultaneous taps, release of held events after STOP, and events that coincide with a read can only be shown by the bench. It replays directed scenarios and a long random mix of strobes, enables and modes against its own per-cycle model.

// File: rtl/irqstat_pkg.sv
package irqstat_pkg;
  localparam int TAP_N   = 6;
  localparam int SRC_N   = TAP_N + 1;
  localparam int STAT_W  = 8;
  localparam int ACQ_POS = STAT_W - 1;
  localparam int SYNC_N  = 2;

  typedef logic [TAP_N-1:0] tap_vec_t;

  typedef struct packed {
    logic     acq;
    tap_vec_t tap;
  } evt_t;

  function automatic tap_vec_t lowest_one(tap_vec_t v);
    return v & (~v + tap_vec_t'(1));
  endfunction
endpackage

// File: rtl/irqstat_pend.sv
module irqstat_pend
  import irqstat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  evt_t evt_in,
  output evt_t evt_out
);
  evt_t pend_q;
  evt_t pend_d;

  always_comb begin
    if (busy) begin
      pend_d  = pend_q | evt_in;
      evt_out = '0;
    end else begin
      pend_d  = '0;
      evt_out = pend_q | evt_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  // R7: an event seen while busy must be held for later
  a_r7_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (evt_in != '0)) |=> (pend_q != '0));
endmodule

// File: rtl/irqstat_flags.sv
module irqstat_flags
  import irqstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  evt_t              set_in,
  input  logic              rd_clr,
  input  logic              first_only,
  output logic [STAT_W-1:0] flags_q
);
  tap_vec_t tap_q;
  tap_vec_t tap_base;
  tap_vec_t tap_add;
  tap_vec_t tap_d;
  tap_vec_t tap_ce;
  logic     acq_q;
  logic     acq_d;
  logic     acq_ce;

  always_comb begin
    tap_base = rd_clr ? '0 : tap_q;
    if (first_only) begin
      tap_add = (tap_base != '0) ? '0 : lowest_one(set_in.tap);
    end else begin
      tap_add = set_in.tap;
    end
    tap_d  = tap_base | tap_add;
    tap_ce = tap_add | {TAP_N{rd_clr}};
    acq_d  = (acq_q & ~rd_clr) | set_in.acq;
    acq_ce = rd_clr | set_in.acq;
  end

  for (genvar i = 0; i < TAP_N; i++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tap_q[i] <= 1'b0;
      else if (tap_ce[i]) tap_q[i] <= tap_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acq_q <= 1'b0;
    else if (acq_ce) acq_q <= acq_d;
  end

  for (genvar b = 0; b < STAT_W; b++) begin : g_word
    if (b < TAP_N) begin : g_t
      assign flags_q[b] = tap_q[b];
    end else if (b == ACQ_POS) begin : g_a
      assign flags_q[b] = acq_q;
    end else begin : g_z
      assign flags_q[b] = 1'b0;
    end
  end

  // R4: a read with nothing arriving leaves an empty word
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && (set_in == '0)) |=> (flags_q == '0));
  // R3: a sample event always lands in the top bit
  a_r3_acq_sets: assert property (@(posedge clk) disable iff (!rst_n)
    set_in.acq |=> flags_q[ACQ_POS]);
  // R6: a latched tap in first-only mode is never joined by another
  a_r6_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (first_only && !rd_clr && (tap_q != '0)) |=> (tap_q == $past(tap_q)));
endmodule

// File: rtl/irqstat_pin.sv
module irqstat_pin
  import irqstat_pkg::*;
(
  input  logic [STAT_W-1:0] flags,
  input  logic [SRC_N-1:0]  en,
  input  logic              pol_high,
  input  logic              push_pull,
  output logic              pin_o,
  output logic              pin_oe
);
  logic [SRC_N-1:0] src;
  logic             act;

  always_comb begin
    src    = {flags[ACQ_POS], flags[TAP_N-1:0]};
    act    = |(src & en);
    pin_o  = pol_high ? act : ~act;
    pin_oe = push_pull | act;
  end
endmodule

// File: rtl/irqstat_top.sv
module irqstat_top
  import irqstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAP_N-1:0]  tap_evt,
  input  logic              smp_evt,
  input  logic              bus_busy,
  input  logic              stat_rd,
  input  logic [SRC_N-1:0]  irq_en,
  input  logic              first_only,
  input  logic              irq_pol_high,
  input  logic              irq_push_pull,
  output logic [STAT_W-1:0] stat_q,
  output logic              irq_o,
  output logic              irq_oe
);
  logic [SYNC_N-1:0] rst_sync_q;
  logic              srst_n;
  evt_t              evt_raw;
  evt_t              evt_apply;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign srst_n = rst_sync_q[SYNC_N-1];

  assign evt_raw.tap = tap_evt;
  assign evt_raw.acq = smp_evt;

  irqstat_pend u_pend (
    .clk    (clk),
    .rst_n  (srst_n),
    .busy   (bus_busy),
    .evt_in (evt_raw),
    .evt_out(evt_apply)
  );

  irqstat_flags u_flags (
    .clk       (clk),
    .rst_n     (srst_n),
    .set_in    (evt_apply),
    .rd_clr    (stat_rd),
    .first_only(first_only),
    .flags_q   (stat_q)
  );

  irqstat_pin u_pin (
    .flags    (stat_q),
    .en       (irq_en),
    .pol_high (irq_pol_high),
    .push_pull(irq_push_pull),
    .pin_o    (irq_o),
    .pin_oe   (irq_oe)
  );

  // R7: the word never gains a bit while the bus is busy
  a_r7_frozen: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_busy && !stat_rd) |=> (stat_q == $past(stat_q)));
  // R8: push-pull always drives the pad
  a_r8_pp_driven: assert property (@(posedge clk) disable iff (!srst_n)
    irq_push_pull |-> irq_oe);
  // R8: open-drain releases the pad while no enabled flag is set
  a_r8_od_release: assert property (@(posedge clk) disable iff (!srst_n)
    (!irq_push_pull && ((stat_q[TAP_N-1:0] & irq_en[TAP_N-1:0]) == '0)
     && !(stat_q[ACQ_POS] && irq_en[TAP_N])) |-> !irq_oe);
  // R5: an enabled sample flag shows on an active-high pin
  a_r5_active_level: assert property (@(posedge clk) disable iff (!srst_n)
    (irq_pol_high && stat_q[ACQ_POS] && irq_en[TAP_N]) |-> irq_o);
endmodule

// File: tb/irqstat_top_test.sv
module irqstat_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 100000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] tap_evt;
  logic       smp_evt, bus_busy, stat_rd, first_only, irq_pol_high, irq_push_pull;
  logic [6:0] irq_en;
  logic [7:0] stat_q;
  logic       irq_o, irq_oe;

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  logic [7:0] m_flags;
  logic [6:0] m_pend;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqstat_top uut (
    .clk(clk), .rst_n(rst_n), .tap_evt(tap_evt), .smp_evt(smp_evt),
    .bus_busy(bus_busy), .stat_rd(stat_rd), .irq_en(irq_en),
    .first_only(first_only), .irq_pol_high(irq_pol_high),
    .irq_push_pull(irq_push_pull), .stat_q(stat_q), .irq_o(irq_o), .irq_oe(irq_oe)
  );

  // behavioural reference, updated at each rising edge
  always @(posedge clk or negedge rst_n) begin
    logic [6:0] inc, applied;
    logic [5:0] t_add;
    logic [7:0] base;
    if (!rst_n) begin
      m_flags = 8'h00;
      m_pend  = 7'h00;
    end else begin
      inc = {smp_evt, tap_evt};
      if (bus_busy) begin
        m_pend  = m_pend | inc;
        applied = 7'h00;
      end else begin
        applied = m_pend | inc;
        m_pend  = 7'h00;
      end
      base  = stat_rd ? 8'h00 : m_flags;
      t_add = applied[5:0];
      if (first_only) begin
        if (base[5:0] != 6'h00) t_add = 6'h00;
        else begin
          for (int i = 0; i < 6; i++)
            if (applied[i]) begin t_add = 6'h00; t_add[i] = 1'b1; break; end
        end
      end
      m_flags = base | {2'b00, t_add} | {applied[6], 7'h00};
    end
  end

  function automatic logic exp_act();
    return (|(m_flags[5:0] & irq_en[5:0])) | (m_flags[7] & irq_en[6]);
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic a;
      a = exp_act();
      n_chk++;
      if (stat_q !== m_flags || irq_o !== (irq_pol_high ? a : !a) || irq_oe !== (irq_push_pull | a)) begin
        n_bad++;
        $display("FAIL %s cycle compare: stat=%02h o=%b oe=%b expected stat=%02h o=%b oe=%b",
                 cur_req, stat_q, irq_o, irq_oe, m_flags, irq_pol_high ? a : !a, irq_push_pull | a);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [7:0] exp);
    n_chk++;
    if (stat_q !== exp) begin
      n_bad++;
      $display("FAIL %s status: actual %02h expected %02h", req, stat_q, exp);
    end
  endtask

  task automatic chk_pin(string req, logic eo, logic eoe);
    n_chk++;
    if (irq_o !== eo || irq_oe !== eoe) begin
      n_bad++;
      $display("FAIL %s pin: actual o=%b oe=%b expected o=%b oe=%b", req, irq_o, irq_oe, eo, eoe);
    end
  endtask

  task automatic do_read();
    stat_rd = 1'b1; step(); stat_rd = 1'b0;
  endtask

  task automatic pulse(logic [5:0] t, logic s);
    tap_evt = t; smp_evt = s; step(); tap_evt = '0; smp_evt = 1'b0;
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tap_evt = '0; smp_evt = 0; bus_busy = 0; stat_rd = 0;
    irq_en = '0; first_only = 0; irq_pol_high = 0; irq_push_pull = 1;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    cur_req = "R1";
    chk("R1", 8'h00);
    chk_pin("R1", 1'b1, 1'b1);
    irq_push_pull = 0; #1;
    chk_pin("R1", 1'b1, 1'b0);
    irq_push_pull = 1;

    cur_req = "R2";
    for (int i = 0; i < 6; i++) begin
      pulse(6'h01 << i, 1'b0);
      chk("R2", 8'h01 << i);
      do_read();
      chk("R4", 8'h00);
    end

    cur_req = "R3";
    first_only = 1;
    pulse(6'h00, 1'b1);
    chk("R3", 8'h80);
    do_read();
    first_only = 0;

    cur_req = "R4";
    pulse(6'h01, 1'b0);
    stat_rd = 1; tap_evt = 6'h04; step(); stat_rd = 0; tap_evt = '0;
    chk("R4", 8'h04);
    do_read();
    chk("R4", 8'h00);

    cur_req = "R5";
    irq_pol_high = 1; irq_en = '0;
    pulse(6'h02, 1'b0);
    chk("R5", 8'h02);
    chk_pin("R5", 1'b0, 1'b1);
    irq_en = 7'h02; #1;
    chk_pin("R5", 1'b1, 1'b1);
    irq_en = 7'h40; #1;
    chk_pin("R5", 1'b0, 1'b1);
    do_read();

    cur_req = "R6";
    first_only = 1;
    pulse(6'h08, 1'b0);
    pulse(6'h01, 1'b0);
    chk("R6", 8'h08);
    do_read();
    pulse(6'h30, 1'b0);
    chk("R6", 8'h10);
    do_read();
    first_only = 0;
    pulse(6'h01, 1'b0);
    pulse(6'h04, 1'b0);
    chk("R6", 8'h05);
    do_read();

    cur_req = "R7";
    bus_busy = 1;
    pulse(6'h20, 1'b1);
    chk("R7", 8'h00);
    step();
    chk("R7", 8'h00);
    bus_busy = 0; step();
    chk("R7", 8'hA0);
    bus_busy = 1; do_read();
    chk("R7", 8'h00);
    bus_busy = 0; step();

    cur_req = "R8";
    irq_push_pull = 0; irq_pol_high = 0; irq_en = 7'h01; #1;
    chk_pin("R8", 1'b1, 1'b0);
    pulse(6'h01, 1'b0);
    chk_pin("R8", 1'b0, 1'b1);
    irq_pol_high = 1; #1;
    chk_pin("R8", 1'b1, 1'b1);
    do_read();
    chk_pin("R8", 1'b0, 1'b0);

    cur_req = "R4/R6/R7";
    for (int c = 0; c < 6000; c++) begin
      tap_evt = ($urandom_range(0, 7) == 0) ? 6'($urandom) : 6'h00;
      smp_evt = ($urandom_range(0, 9) == 0);
      stat_rd = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 11) == 0) bus_busy = ~bus_busy;
      if (c % 200 == 0) first_only = $urandom_range(0, 1);
      if (c % 100 == 0) begin
        irq_en = 7'($urandom);
        irq_pol_high = $urandom_range(0, 1);
        irq_push_pull = $urandom_range(0, 1);
      end
      step();
    end
    tap_evt = '0; smp_evt = 0; stat_rd = 0; bus_busy = 0;
    step();
    @(negedge clk); #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule